// File: doc/BRIEF.md
# Eight-input prioritised interrupt controller

This block collects up to eight interrupt requests and presents the most urgent one to a CPU on a single interrupt line. It keeps three byte-wide registers: pending requests, requests currently being serviced, and a block mask. A resolver with fixed priority compares them, and input 0 is the most urgent. When the CPU acknowledges, the block returns a vector byte. The upper bits of that byte come from a programmable base and the low three bits give the winning input number.

The CPU reaches the block through a byte port with two addresses: an even command address (`addr`=0) and an odd data address (`addr`=1). After reset the block stays silent until software sends a configuration sequence of two to four words. Bits in the first word decide which of the later words are expected. Once configured, odd-address writes load the mask. Even-address writes carry end-of-service commands, or they choose which register the next even-address read returns. The third word only stores a cascade descriptor, and that descriptor is brought out as a port.

Top module: `pic_ctrl`

## Requirements
- R1: After reset `irq_out` is 0, `vector` is 0x00, `casc_cfg` is 0x00, an even-address read returns 0x00 and an odd-address read returns 0x00.
- R2: An even-address write with bit 4 set starts configuration. From then until the last expected word has arrived, `irq_out` stays 0, inputs are ignored, and a request that rose during that window is not latched.
- R3: In the first word, bit 1 = 1 means single mode, bit 0 = 1 means a fourth word follows, and bit 3 = 1 selects level capture. The second word (odd address) loads the vector base from bits 7:3. Outside single mode the third odd-address word is captured on `casc_cfg`; in single mode that word is skipped. The fourth word is taken only when requested, and its bit 1 selects automatic end-of-service. Any later odd-address write loads the mask.
- R4: An acknowledge (`ack` high for one cycle while `irq_out` is 1) moves the winning bit from the pending register to the in-service register. From the next cycle, `vector` equals {base[7:3], winner[2:0]}.
- R5: Among pending, unmasked inputs, the lowest-numbered one wins.
- R6: Mask bit n set to 1 blocks input n from `irq_out`, but the request is still latched and can be read back. A mask of 0xFF blocks every input.
- R7: A request is forwarded only if its number is below every bit set in the in-service register.
- R8: The even-address command 0x20 clears only the lowest-numbered in-service bit.
- R9: The even-address command 0x60|n clears in-service bit n, whichever other bits are set.
- R10: The even-address command 0x0A makes later even-address reads return the pending register, and 0x0B makes them return the in-service register. Odd-address reads always return the mask.
- R11: In edge mode a rising input sets its pending bit, and the bit stays set after the input falls until it is acknowledged. In level mode the pending register follows the inputs.
- R12: With automatic end-of-service selected, an acknowledge leaves the in-service register at 0.
- R13: An acknowledge while `irq_out` is 0 after configuration returns `vector` = {base, 3'b111} and leaves the in-service register unchanged.
- R14: A new first word clears the in-service, pending and mask registers and `casc_cfg`, and selects pending-register readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current `addr` |
| irq_in | input | 8 | Interrupt request inputs, input 0 most urgent |
| ack | input | 1 | Acknowledge pulse from the CPU |
| irq_out | output | 1 | Interrupt line to the CPU |
| vector | output | 8 | Vector byte from the last acknowledge |
| casc_cfg | output | 8 | Stored cascade descriptor (third word) |

## Verification
The assertions check the following on every cycle:
- `irq_out` stays silent while the block is not configured.
- A forwarded winner is unmasked, has the lowest number among the pending inputs, and lies above all in-service levels.
- Every acknowledge records its level in the in-service register and in the vector.
- Each end-of-service command removes the intended bit.
- Automatic mode never holds anything in service.

Only the bench's scenarios show the rest:
- how the configuration words are sequenced, including the skipped third word;
- the exact vector value for each priority pattern and each mask;
- the difference between edge and level capture;
- the readback steering.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_N  = 8;
  localparam int LVL_W  = $clog2(PIC_N);
  localparam int BASE_W = PIC_N - LVL_W;

  typedef logic [PIC_N-1:0] vec_t;
  typedef logic [LVL_W:0]   rank_t;   // value PIC_N means "no bit set"

  typedef enum logic [2:0] {ST_BOOT, ST_W2, ST_W3, ST_W4, ST_RUN} init_st_e;

  // Command byte field positions (decoded by the configuration unit)
  localparam int F_INIT = 4;
  localparam int F_SEL  = 3;

  localparam logic [2:0] EOI_NONSPEC = 3'b001;
  localparam logic [2:0] EOI_SPEC    = 3'b011;

  // Index of the lowest set bit, or PIC_N when empty
  function automatic rank_t first_set(vec_t v);
    rank_t r;
    r = rank_t'(PIC_N);
    for (int i = PIC_N - 1; i >= 0; i--)
      if (v[i]) r = rank_t'(i);
    return r;
  endfunction

  function automatic vec_t level_oh(logic [LVL_W-1:0] l);
    return vec_t'(1) << l;
  endfunction

  // State following the base word, from the first-word options
  function automatic init_st_e after_base(logic single, logic need4);
    if (!single) return ST_W3;
    return need4 ? ST_W4 : ST_RUN;
  endfunction
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  vec_t              wdata,
  output logic              ready,
  output logic              level_mode,
  output logic              aeoi_mode,
  output logic [BASE_W-1:0] base,
  output vec_t              casc,
  output vec_t              imr,
  output logic              sel_isr,
  output logic              init_pulse,
  output logic              eoi_ns,
  output logic              eoi_sp,
  output logic [LVL_W-1:0]  eoi_lvl
);
  init_st_e st_q;
  logic     need4_q, single_q;
  logic     cmd_even, status_cmd, data_wr;

  assign ready      = (st_q == ST_RUN);
  assign init_pulse = wr_en && !addr && wdata[F_INIT];
  assign cmd_even   = wr_en && !addr && !wdata[F_INIT] && ready;
  assign eoi_ns     = cmd_even && !wdata[F_SEL] && (wdata[7:5] == EOI_NONSPEC);
  assign eoi_sp     = cmd_even && !wdata[F_SEL] && (wdata[7:5] == EOI_SPEC);
  assign eoi_lvl    = wdata[LVL_W-1:0];
  assign status_cmd = cmd_even && wdata[F_SEL];
  assign data_wr    = wr_en && addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_BOOT;
      need4_q    <= 1'b0;
      single_q   <= 1'b0;
      level_mode <= 1'b0;
      aeoi_mode  <= 1'b0;
      base       <= '0;
      casc       <= '0;
      imr        <= '0;
      sel_isr    <= 1'b0;
    end else if (init_pulse) begin
      st_q       <= ST_W2;
      need4_q    <= wdata[0];
      single_q   <= wdata[1];
      level_mode <= wdata[3];
      aeoi_mode  <= 1'b0;
      casc       <= '0;
      imr        <= '0;
      sel_isr    <= 1'b0;
    end else begin
      if (data_wr) begin
        case (st_q)
          ST_W2: begin
            base <= wdata[PIC_N-1:LVL_W];
            st_q <= after_base(single_q, need4_q);
          end
          ST_W3: begin
            casc <= wdata;
            st_q <= need4_q ? ST_W4 : ST_RUN;
          end
          ST_W4: begin
            aeoi_mode <= wdata[1];
            st_q      <= ST_RUN;
          end
          ST_RUN:  imr <= wdata;
          default: ;
        endcase
      end
      if (status_cmd && wdata[1]) sel_isr <= wdata[0];
    end
  end

  assert_restart_clears_R14: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (!ready && imr == '0 && casc == '0 && !sel_isr));
endmodule

// File: rtl/pic_capture.sv
module pic_capture
  import pic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic init_pulse,
  input  logic level_mode,
  input  vec_t irq_in,
  input  vec_t clr,
  output vec_t irr
);
  vec_t prev_q;
  vec_t rise;

  assign rise = irq_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr    <= '0;
    end else begin
      prev_q <= irq_in;
      if (!ready || init_pulse) irr <= '0;
      else if (level_mode)      irr <= irq_in;
      else                      irr <= (irr & ~clr) | rise;
    end
  end

  assert_clear_while_unready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> irr == '0);

  assert_edge_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !level_mode && !init_pulse && clr == '0) |=> ((irr & $past(irr)) == $past(irr)));
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
  import pic_pkg::*;
(
  input  logic             ready,
  input  vec_t             irr,
  input  vec_t             imr,
  input  vec_t             isr,
  output logic             req,
  output logic [LVL_W-1:0] win_idx,
  output vec_t             win_oh
);
  rank_t pend_rank, svc_rank;

  always_comb begin
    pend_rank = first_set(irr & ~imr);
    svc_rank  = first_set(isr);
    req       = ready && (pend_rank < svc_rank);
    win_idx   = pend_rank[LVL_W-1:0];
    win_oh    = req ? level_oh(win_idx) : '0;
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [PIC_N-1:0] wdata,
  output logic [PIC_N-1:0] rdata,
  input  logic [PIC_N-1:0] irq_in,
  input  logic             ack,
  output logic             irq_out,
  output logic [PIC_N-1:0] vector,
  output logic [PIC_N-1:0] casc_cfg
);
  logic              ready, level_mode, aeoi_mode, sel_isr;
  logic              init_pulse, eoi_ns, eoi_sp;
  logic [LVL_W-1:0]  eoi_lvl, win_idx;
  logic [BASE_W-1:0] base;
  vec_t              imr, irr, isr_q, win_oh, eoi_clr, ack_clr, at_or_above;
  rank_t             isr_top;
  logic              req, take, spur;

  pic_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ready(ready), .level_mode(level_mode), .aeoi_mode(aeoi_mode), .base(base),
    .casc(casc_cfg), .imr(imr), .sel_isr(sel_isr), .init_pulse(init_pulse),
    .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_lvl(eoi_lvl)
  );

  pic_capture u_cap (
    .clk(clk), .rst_n(rst_n), .ready(ready), .init_pulse(init_pulse),
    .level_mode(level_mode), .irq_in(irq_in), .clr(ack_clr), .irr(irr)
  );

  pic_resolve u_res (
    .ready(ready), .irr(irr), .imr(imr), .isr(isr_q),
    .req(req), .win_idx(win_idx), .win_oh(win_oh)
  );

  // Acknowledge events
  assign take    = ack && req;
  assign spur    = ack && ready && !req;
  assign ack_clr = take ? win_oh : '0;
  assign irq_out = req;

  // End-of-service decode
  always_comb begin
    isr_top = first_set(isr_q);
    eoi_clr = '0;
    if (eoi_ns && isr_q != '0) eoi_clr = level_oh(isr_top[LVL_W-1:0]);
    if (eoi_sp)                eoi_clr = level_oh(eoi_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          isr_q <= '0;
    else if (init_pulse) isr_q <= '0;
    else                 isr_q <= (isr_q & ~eoi_clr) | ((take && !aeoi_mode) ? win_oh : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vector <= '0;
    else if (take) vector <= {base, win_idx};
    else if (spur) vector <= {base, {LVL_W{1'b1}}};
  end

  assign rdata = addr ? imr : (sel_isr ? isr_q : irr);

  // Mask of the winner and every more urgent level
  assign at_or_above = vec_t'(win_oh << 1) - vec_t'(1);

  assert_quiet_until_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !irq_out);
  assert_vector_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> vector[LVL_W-1:0] == $past(win_idx));
  assert_ack_records_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !aeoi_mode && !eoi_ns && !eoi_sp) |=> (isr_q & $past(win_oh)) != '0);
  assert_fixed_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (irr & ~imr & (win_oh - vec_t'(1))) == '0);
  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (win_oh & imr) == '0);
  assert_nesting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (isr_q & at_or_above) == '0);
  assert_ns_eoi_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ns && !take && isr_q != '0) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
  assert_sp_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_sp && !take) |=> !isr_q[$past(eoi_lvl)]);
  assert_auto_eoi_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi_mode |-> isr_q == '0);
  assert_spurious_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (spur && !eoi_ns && !eoi_sp) |=> (vector[LVL_W-1:0] == '1 && $stable(isr_q)));
endmodule

// File: tb/pic_ctrl_tb.sv
module pic_ctrl_tb;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, vector, casc_cfg;
  logic       irq_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_in(irq_in), .ack(ack), .irq_out(irq_out), .vector(vector), .casc_cfg(casc_cfg)
  );

  task automatic step(); @(posedge clk); @(negedge clk); endtask
  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d; step(); wr_en = 1'b0;
  endtask
  task automatic pulse_ack(); ack = 1'b1; step(); ack = 1'b0; endtask
  task automatic rd(input logic a, output logic [7:0] d); addr = a; #1; d = rdata; endtask
  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask
  task automatic fire(input logic [7:0] v); irq_in = v; step(); irq_in = '0; endtask
  function automatic int top_bit(input logic [7:0] v);
    int r = 8;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) step();
    rst_n = 1'b1; step();

    // R1 reset state
    chk({7'd0, irq_out}, 8'h00, "R1 irq_out");
    chk(vector, 8'h00, "R1 vector");
    chk(casc_cfg, 8'h00, "R1 casc_cfg");
    rd(0, d); chk(d, 8'h00, "R1 even read");
    rd(1, d); chk(d, 8'h00, "R1 odd read");

    // R2 silent before and during configuration
    fire(8'h08); chk({7'd0, irq_out}, 0, "R2 before config");
    wr(0, 8'h12); fire(8'h08);
    chk({7'd0, irq_out}, 0, "R2 mid config");
    wr(1, 8'h20); step();
    chk({7'd0, irq_out}, 0, "R2 rise during config not latched");
    rd(0, d); chk(d, 8'h00, "R2 pending empty");

    // R4 R8 R10 R11 each input alone
    for (int i = 0; i < 8; i++) begin
      fire(8'(1 << i));
      chk({7'd0, irq_out}, 1, "R4 single request forwarded");
      rd(0, d); chk(d, 8'(1 << i), "R11 edge latched after fall");
      pulse_ack();
      chk(vector, 8'h20 | 8'(i), "R4 vector");
      rd(0, d); chk(d, 8'h00, "R4 pending cleared");
      wr(0, 8'h0B); rd(0, d); chk(d, 8'(1 << i), "R10 in-service readback");
      chk({7'd0, irq_out}, 0, "R7 no re-forward");
      wr(0, 8'h20); rd(0, d); chk(d, 8'h00, "R8 nonspecific clears");
      wr(0, 8'h0A);
    end

    // R5 every request pattern
    for (int v = 1; v < 256; v++) begin
      wr(0, 8'h12); wr(1, 8'h40);
      fire(8'(v));
      chk({7'd0, irq_out}, 1, "R5 forwarded");
      pulse_ack();
      chk(vector, 8'h40 | 8'(top_bit(8'(v))), "R5 winner");
      rd(0, d); chk(d, 8'(v) & ~8'(1 << top_bit(8'(v))), "R4 winner moved out");
    end

    // R6 every mask value
    for (int m = 0; m < 256; m++) begin
      wr(0, 8'h12); wr(1, 8'h40); wr(1, 8'(m));
      rd(1, d); chk(d, 8'(m), "R6 mask readback");
      fire(8'hFF);
      rd(0, d); chk(d, 8'hFF, "R6 masked still latched");
      chk({7'd0, irq_out}, {7'd0, m != 255}, "R6 forwarding");
      if (m != 255) begin
        pulse_ack();
        chk(vector, 8'h40 | 8'(top_bit(~8'(m))), "R6 unmasked winner");
      end
    end

    // R7 R8 R9 nesting
    wr(0, 8'h12); wr(1, 8'h20);
    fire(8'h10); pulse_ack();
    fire(8'h20); chk({7'd0, irq_out}, 0, "R7 lower level blocked");
    fire(8'h04); chk({7'd0, irq_out}, 1, "R7 higher level forwarded");
    pulse_ack(); chk(vector, 8'h22, "R7 nested vector");
    wr(0, 8'h0B); rd(0, d); chk(d, 8'h14, "R7 two in service");
    wr(0, 8'h20); rd(0, d); chk(d, 8'h10, "R8 only most urgent cleared");
    chk({7'd0, irq_out}, 0, "R7 still blocked");
    wr(0, 8'h64); rd(0, d); chk(d, 8'h00, "R9 specific clear");
    chk({7'd0, irq_out}, 1, "R7 released");
    pulse_ack(); chk(vector, 8'h25, "R4 vector after release");
    fire(8'h01); pulse_ack();
    rd(0, d); chk(d, 8'h21, "R9 setup");
    wr(0, 8'h65); rd(0, d); chk(d, 8'h01, "R9 clears a less urgent bit");
    wr(0, 8'h20); rd(0, d); chk(d, 8'h00, "R8 last bit");

    // R13 spurious acknowledge
    pulse_ack(); chk(vector, 8'h27, "R13 spurious vector");
    rd(0, d); chk(d, 8'h00, "R13 in-service unchanged");

    // R10 pending readback and mask readback
    wr(1, 8'h80); fire(8'h80); wr(0, 8'h0A);
    rd(0, d); chk(d, 8'h80, "R10 pending readback");
    rd(1, d); chk(d, 8'h80, "R10 odd read is mask");

    // R14 restart
    wr(1, 8'h3C); fire(8'h01); pulse_ack(); wr(0, 8'h0B);
    wr(0, 8'h12);
    rd(1, d); chk(d, 8'h00, "R14 mask cleared");
    wr(1, 8'h20);
    fire(8'h02);
    rd(0, d); chk(d, 8'h02, "R14 pending readback selected");
    chk({7'd0, irq_out}, 1, "R14 in-service cleared");

    // R11 level capture
    wr(0, 8'h1A); wr(1, 8'h20);
    irq_in = 8'h40; step();
    rd(0, d); chk(d, 8'h40, "R11 level pending");
    chk({7'd0, irq_out}, 1, "R11 level forwarded");
    irq_in = 8'h00; step();
    rd(0, d); chk(d, 8'h00, "R11 level follows input");
    chk({7'd0, irq_out}, 0, "R11 level dropped");

    // R3 cascaded with a fourth word
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04);
    chk(casc_cfg, 8'h04, "R3 cascade word stored");
    fire(8'h01); chk({7'd0, irq_out}, 0, "R3 waits for fourth word");
    wr(1, 8'h01); wr(1, 8'h0F);
    rd(1, d); chk(d, 8'h0F, "R3 mask after fourth word");

    // R3 R12 single mode with fourth word, automatic end of service
    wr(0, 8'h13); wr(1, 8'h48); wr(1, 8'h03);
    chk(casc_cfg, 8'h00, "R3 third word skipped");
    rd(1, d); chk(d, 8'h00, "R3 word went to options not mask");
    fire(8'h02); pulse_ack();
    chk(vector, 8'h49, "R12 vector");
    wr(0, 8'h0B); rd(0, d); chk(d, 8'h00, "R12 nothing in service");
    fire(8'h04); chk({7'd0, irq_out}, 1, "R12 next request not blocked");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule